// File: doc/BRIEF.md
# Pipelined Sine/Cosine Generator from a Half-Period Table

This block turns a fixed-point shaft angle into one trigonometric value per clock. A 12-bit angle divides the full turn into 4096 equal steps. A 2-bit function code picks sine, cosine, negated sine or negated cosine. The block adds the code to the two upper angle bits, which advances the angle by whole quarter turns. The lower bits of the resulting angle address a table that holds the positive half of a sine wave. The top bit then decides whether the value read from the table is negated.

The unit is fully pipelined. It accepts a new angle on every clock, and the result appears a fixed number of cycles later together with a valid strobe. A vector-rotation datapath that needs sin and cos of the same angle can issue two requests on consecutive cycles and get both results back in order. The table contents are computed by a function when the design starts, so no external initialisation data is needed.

Top module: `sincos_halfwave`

## Requirements
- R1: A request presented with `ang_vld_i` high in cycle t produces `res_vld_o` high in cycle t+6 and in no other cycle; one request is accepted every clock with no stall.
- R2: While `rst_ni` is low, `res_vld_o` is 0 and `res_o` is 0.
- R3: With `fn_sel_i` = 0 (sine), the result for angle a equals S(a). S(e) for e in 0..2047 is T(e) = floor(65535·sin(π·e/2048) + 0.5). S(e) for e in 2048..4095 is −T(e−2048).
- R4: With `fn_sel_i` = 1 (cosine), the result equals S((a + 1024) mod 4096).
- R5: With `fn_sel_i` = 2 the result is S((a + 2048) mod 4096), which is −sin. With `fn_sel_i` = 3 the result is S((a + 3072) mod 4096), which is −cos.
- R6: When the effective angle has bit 11 set, the result is the two's complement negation of the table value at the lower 11 bits. It is never positive. When bit 11 is clear, the result is never negative.
- R7: Effective angles 0 and 2048 give exactly 0. Effective angle 1024 gives +65535. Effective angle 3072 gives −65535.
- R8: The quarter-turn offset wraps modulo a full turn. For example, angle 3500 with `fn_sel_i` = 3 uses effective angle 2476.
- R9: A cycle with `ang_vld_i` low yields `res_vld_o` low six cycles later, however it is interleaved with valid requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ang_i | input | 12 | Angle, unsigned, 4096 steps per turn |
| fn_sel_i | input | 2 | Function code: 0 sin, 1 cos, 2 −sin, 3 −cos |
| ang_vld_i | input | 1 | Request valid |
| res_o | output | 18 | Result, signed two's complement, full scale ±65535 |
| res_vld_o | output | 1 | Result valid, six cycles after the request |

## Verification
A misaligned sign bit shows up at the ports within six cycles as a wrong-signed result wherever consecutive requests cross the half-turn. An adder that does not wrap the quarter-turn offset correctly gives wrong values for cosine and negated functions near the end of the turn. A valid strobe that slips out of step with the data shows up as a strobe one cycle early or late on the first isolated request. The reference model checks every output cycle against the exact rounded sine, so a single bad table entry or a wrong negation is caught on the first request that uses it.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

   // Function codes applied to the two upper angle bits
   localparam logic [1:0] FN_SIN  = 2'd0;
   localparam logic [1:0] FN_COS  = 2'd1;
   localparam logic [1:0] FN_NSIN = 2'd2;
   localparam logic [1:0] FN_NCOS = 2'd3;

   localparam real HALF_TURN_RAD = 3.14159265358979323846;

   // One rounded sample of the positive half-wave: idx in [0, depth)
   function automatic int half_sine(input int idx, input int depth, input int amp);
      real ph;
      real v;
      ph = HALF_TURN_RAD * real'(idx) / real'(depth);
      v  = real'(amp) * $sin(ph) + 0.5;
      return $rtoi(v);
   endfunction

endpackage

// File: rtl/sincos_addr.sv
// Two stages: capture of the request, then quarter-turn offset added to the top bits.
module sincos_addr #(
   parameter int ANG_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ANG_W-1:0] ang_i,
   input  logic [1:0]       sel_i,
   input  logic             vld_i,
   output logic [ANG_W-1:0] eff_o,
   output logic             vld_o
);
   localparam int LOW_W = ANG_W - 2;

   logic [ANG_W-1:0] ang_q;
   logic [1:0]       sel_q;
   logic             vld_q;
   logic [1:0]       top_sum;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ang_q <= '0;
         sel_q <= '0;
         vld_q <= 1'b0;
      end else begin
         ang_q <= ang_i;
         sel_q <= sel_i;
         vld_q <= vld_i;
      end
   end

   // 2-bit add wraps naturally: offset is modulo one full turn
   assign top_sum = ang_q[ANG_W-1 -: 2] + sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         eff_o <= '0;
         vld_o <= 1'b0;
      end else begin
         eff_o <= {top_sum, ang_q[LOW_W-1:0]};
         vld_o <= vld_q;
      end
   end
endmodule

// File: rtl/sincos_rom.sv
// Half-wave table with a registered read; the angle MSB and valid travel
// through the same number of stages as the data.
module sincos_rom #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 18,
   parameter int AMP       = 65535,
   parameter int RD_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              msb_i,
   input  logic              vld_i,
   output logic [DATA_W-1:0] dat_o,
   output logic              msb_o,
   output logic              vld_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0]    tbl [DEPTH];
   logic [DATA_W-1:0]    dq  [RD_STAGES];
   logic [RD_STAGES-1:0] mq;
   logic [RD_STAGES-1:0] vq;

   initial begin
      for (int k = 0; k < DEPTH; k++) begin
         tbl[k] = DATA_W'(sincos_pkg::half_sine(k, DEPTH, AMP));
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int g = 0; g < RD_STAGES; g++) dq[g] <= '0;
         mq <= '0;
         vq <= '0;
      end else begin
         dq[0] <= tbl[addr_i];
         mq[0] <= msb_i;
         vq[0] <= vld_i;
         for (int g = 1; g < RD_STAGES; g++) begin
            dq[g] <= dq[g-1];
            mq[g] <= mq[g-1];
            vq[g] <= vq[g-1];
         end
      end
   end

   assign dat_o = dq[RD_STAGES-1];
   assign msb_o = mq[RD_STAGES-1];
   assign vld_o = vq[RD_STAGES-1];
endmodule

// File: rtl/sincos_sign.sv
// Sign restoration stage followed by the output register.
module sincos_sign #(
   parameter int DATA_W   = 18,
   parameter bit NEG_FAST = 1'b0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [DATA_W-1:0]        dat_i,
   input  logic                     msb_i,
   input  logic                     vld_i,
   output logic signed [DATA_W-1:0] res_o,
   output logic                     vld_o
);
   logic signed [DATA_W-1:0] mag;
   logic signed [DATA_W-1:0] fixed_d;
   logic signed [DATA_W-1:0] fixed_q;
   logic                     vld_q;

   assign mag = $signed(dat_i);

   generate
      if (NEG_FAST) begin : g_xor_neg
         // Ones' complement plus carry-in, same result as a subtractor
         logic signed [DATA_W-1:0] inv;
         assign inv     = mag ^ {DATA_W{msb_i}};
         assign fixed_d = inv + $signed({{(DATA_W-1){1'b0}}, msb_i});
      end else begin : g_sub_neg
         assign fixed_d = msb_i ? -mag : mag;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fixed_q <= '0;
         vld_q   <= 1'b0;
         res_o   <= '0;
         vld_o   <= 1'b0;
      end else begin
         fixed_q <= fixed_d;
         vld_q   <= vld_i;
         res_o   <= fixed_q;
         vld_o   <= vld_q;
      end
   end
endmodule

// File: rtl/sincos_halfwave.sv
module sincos_halfwave #(
   parameter int ANG_W     = 12,
   parameter int DATA_W    = 18,
   parameter int AMP       = 65535,
   parameter int RD_STAGES = 2,
   parameter bit NEG_FAST  = 1'b0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [ANG_W-1:0]         ang_i,
   input  logic [1:0]               fn_sel_i,
   input  logic                     ang_vld_i,
   output logic signed [DATA_W-1:0] res_o,
   output logic                     res_vld_o
);
   localparam int ADDR_W  = ANG_W - 1;
   localparam int LATENCY = RD_STAGES + 4;

   generate
      if (ANG_W < 4 || ANG_W > 16) begin : g_bad_ang
         $error("sincos_halfwave: ANG_W out of range");
      end
      if (RD_STAGES < 1 || RD_STAGES > 4) begin : g_bad_rd
         $error("sincos_halfwave: RD_STAGES must be 1..4");
      end
      if (AMP < 1 || AMP >= (1 << (DATA_W - 1))) begin : g_bad_amp
         $error("sincos_halfwave: AMP does not fit the signed result");
      end
      if (LATENCY < 5) begin : g_bad_lat
         $error("sincos_halfwave: latency derivation broken");
      end
   endgenerate

   logic [ANG_W-1:0]  eff;
   logic              eff_vld;
   logic [DATA_W-1:0] tdat;
   logic              tmsb;
   logic              tvld;

   sincos_addr #(.ANG_W(ANG_W)) u_addr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ang_i  (ang_i),
      .sel_i  (fn_sel_i),
      .vld_i  (ang_vld_i),
      .eff_o  (eff),
      .vld_o  (eff_vld)
   );

   sincos_rom #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .AMP       (AMP),
      .RD_STAGES (RD_STAGES)
   ) u_rom (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (eff[ADDR_W-1:0]),
      .msb_i  (eff[ANG_W-1]),
      .vld_i  (eff_vld),
      .dat_o  (tdat),
      .msb_o  (tmsb),
      .vld_o  (tvld)
   );

   sincos_sign #(.DATA_W(DATA_W), .NEG_FAST(NEG_FAST)) u_sign (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dat_i  (tdat),
      .msb_i  (tmsb),
      .vld_i  (tvld),
      .res_o  (res_o),
      .vld_o  (res_vld_o)
   );
endmodule

// File: rtl/sincos_halfwave_chk.sv
module sincos_halfwave_chk #(
   parameter int ANG_W   = 12,
   parameter int DATA_W  = 18,
   parameter int AMP     = 65535,
   parameter int LATENCY = 6
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic [ANG_W-1:0]         ang_i,
   input logic [1:0]               fn_sel_i,
   input logic                     ang_vld_i,
   input logic signed [DATA_W-1:0] res_o,
   input logic                     res_vld_o
);
   localparam logic [ANG_W-1:0] QTR  = ANG_W'(1) << (ANG_W - 2);
   localparam logic [ANG_W-1:0] HALF = ANG_W'(1) << (ANG_W - 1);
   localparam logic [ANG_W-1:0] TQTR = QTR + HALF;
   localparam logic signed [DATA_W-1:0] PK = DATA_W'(AMP);

   logic [LATENCY-1:0] vh;
   logic [ANG_W-1:0]   eh [LATENCY];
   logic [ANG_W-1:0]   eff_in;
   logic [ANG_W-1:0]   e_out;
   logic               v_out;

   assign eff_in = ang_i + (ANG_W'(fn_sel_i) << (ANG_W - 2));
   assign e_out  = eh[LATENCY-1];
   assign v_out  = vh[LATENCY-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vh <= '0;
         for (int k = 0; k < LATENCY; k++) eh[k] <= '0;
      end else begin
         vh    <= {vh[LATENCY-2:0], ang_vld_i};
         eh[0] <= eff_in;
         for (int k = 1; k < LATENCY; k++) eh[k] <= eh[k-1];
      end
   end

   // R1
   lat_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_vld_o == v_out);

   // R2
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         rst_quiet_chk: assert (!res_vld_o && res_o == '0);
      end
   end

   // R6
   neg_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_out && e_out[ANG_W-1]) |-> (res_o <= 0));

   // R6
   pos_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_out && !e_out[ANG_W-1]) |-> (res_o >= 0));

   // R7
   zero_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_out && (e_out == '0 || e_out == HALF)) |-> (res_o == '0));

   // R7
   pos_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_out && e_out == QTR) |-> (res_o == PK));

   // R7
   neg_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_out && e_out == TQTR) |-> (res_o == -PK));
endmodule

bind sincos_halfwave sincos_halfwave_chk #(
   .ANG_W   (ANG_W),
   .DATA_W  (DATA_W),
   .AMP     (AMP),
   .LATENCY (LATENCY)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .ang_i     (ang_i),
   .fn_sel_i  (fn_sel_i),
   .ang_vld_i (ang_vld_i),
   .res_o     (res_o),
   .res_vld_o (res_vld_o)
);

// File: tb/sincos_halfwave_test.sv
`timescale 1ns/1ps
module sincos_halfwave_test;
   localparam int LAT = 6;

   typedef struct {
      bit    v;
      int    y;
      string tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b1;
   logic [11:0]        ang = '0;
   logic [1:0]         sel = '0;
   logic               vld = 1'b0;
   logic signed [17:0] res;
   logic               res_vld;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   cyc = 0;
   exp_t q[$];

   sincos_halfwave uut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .ang_i     (ang),
      .fn_sel_i  (sel),
      .ang_vld_i (vld),
      .res_o     (res),
      .res_vld_o (res_vld)
   );

   always #4 clk = ~clk;

   function automatic int ref_val(input int a, input int s);
      int  e;
      int  k;
      int  t;
      real r;
      e = (a + s * 1024) % 4096;
      k = e % 2048;
      r = 65535.0 * $sin(3.14159265358979323846 * real'(k) / 2048.0) + 0.5;
      t = $rtoi(r);
      return (e >= 2048) ? -t : t;
   endfunction

   function automatic string tag_of(input int a, input int s, input bit v);
      int e;
      e = (a + s * 1024) % 4096;
      if (!v)                 return "R9";
      if (e % 1024 == 0)      return "R7";
      if (a + s * 1024 >= 4096) return "R8";
      if (e >= 2048)          return "R6";
      if (s == 0)             return "R3";
      if (s == 1)             return "R4";
      return "R5";
   endfunction

   // Record what the design samples at each edge
   always @(posedge clk) begin
      exp_t x;
      cyc++;
      if (!rst_n) begin
         x.v = 1'b0; x.y = 0; x.tag = "R2";
      end else begin
         x.v   = vld;
         x.y   = ref_val(int'(ang), int'(sel));
         x.tag = tag_of(int'(ang), int'(sel), vld);
      end
      q.push_back(x);
      if (q.size() > LAT) void'(q.pop_front());
      if (cyc > 200000) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 200000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // Compare away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         n_cmp++;
         if (res_vld !== 1'b0 || res !== '0) begin
            n_bad++;
            $display("FAIL R2: reset outputs vld=%0b res=%0d expected vld=0 res=0", res_vld, res);
         end
      end else if (q.size() >= LAT) begin
         exp_t e;
         e = q[q.size() - LAT];
         n_cmp++;
         if (res_vld !== e.v) begin
            n_bad++;
            $display("FAIL R1 (%s): res_vld_o actual %0b expected %0b", e.tag, res_vld, e.v);
         end else if (e.v && int'(res) != e.y) begin
            n_bad++;
            $display("FAIL %s: res_o actual %0d expected %0d", e.tag, res, e.y);
         end
      end
   end

   task automatic drive(input int a, input int s, input bit v);
      @(negedge clk);
      ang = 12'(a);
      sel = 2'(s);
      vld = v;
   endtask

   initial begin
      int pts[10] = '{0, 1, 1023, 1024, 1025, 2047, 2048, 2049, 3072, 4095};
      #2 rst_n = 1'b0;
      repeat (5) @(negedge clk);
      // R2: inputs toggling during reset must not reach the outputs
      ang = 12'd1024; vld = 1'b1;
      repeat (3) @(negedge clk);
      vld = 1'b0;
      rst_n = 1'b1;
      repeat (8) drive(0, 0, 0);
      // R3 R4 R5 R6 R7: each function over landmark angles, back to back
      for (int s = 0; s < 4; s++) begin
         foreach (pts[i]) drive(pts[i], s, 1);
      end
      // R9: gaps interleaved with requests
      for (int i = 0; i < 20; i++) drive(i * 211, i % 4, i[0]);
      // R8: wrap of the quarter-turn offset
      drive(3500, 3, 1);
      drive(4000, 1, 1);
      drive(3071, 2, 1);
      drive(2048, 3, 1);
      // R1: isolated request between idle cycles
      repeat (3) drive(0, 0, 0);
      drive(700, 1, 1);
      repeat (8) drive(0, 0, 0);
      // Broad sweep with random gaps
      for (int i = 0; i < 6000; i++) begin
         drive(int'($urandom_range(4095)), int'($urandom_range(3)), ($urandom_range(3) != 0));
      end
      // Exhaustive sine sweep for R3 and R6 over every table entry
      for (int a = 0; a < 4096; a++) drive(a, 0, 1);
      repeat (10) drive(0, 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule